// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of a 32-pin general-purpose I/O port. It sits on a simple valid/ready register bus and decodes 32-bit word accesses within a 4 KB window. It holds an output latch, a port-wide direction register, a sampled copy of the resolved pin levels, and one configuration word per pin. Set and clear aliases let software change single output or direction bits without a read-modify-write.

Its outputs feed a separate per-pin pad resolver: the latch, the direction bits and every configuration word. The resolved input levels come back on `pad_in_i` and are sampled every cycle. Pin direction appears in two views, the direction register and bit 0 of each configuration word. The two views are always kept consistent, because both are backed by one storage bit per pin.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the latch and direction outputs are 0, every configuration word is 0x00000002, and the error flag is low.
- R2: A write to offset 0x504 replaces the output latch. A read of 0x504, 0x508 or 0x50C returns the latch.
- R3: A write to 0x508 ORs the data into the latch. A write to 0x50C clears every latch bit that is 1 in the data.
- R4: A write to 0x514 replaces the direction register. A read of 0x514, 0x518 or 0x51C returns the direction register.
- R5: A write to 0x518 sets the direction bits that are 1 in the data. A write to 0x51C clears them.
- R6: Any change to the direction register changes bit 0 of configuration word i to direction bit i. Bits [31:1] of every configuration word are left unchanged.
- R7: Configuration word i lives at 0x700 + 4*i, with index bits [6:2] of the offset. A write there replaces the whole word and copies data bit 0 into direction bit i.
- R8: A read of 0x510 returns `pad_in_i` as it was two clock edges before the read data appears. A write to 0x510 has no effect and raises no error.
- R9: An access to an unmapped or non-word-aligned offset returns read data 0, raises the error flag, and leaves the latch, direction and configuration unchanged.
- R10: `req_ready_o` is always high. Read data and the error flag appear in the cycle after the access is accepted, and the error flag lasts one cycle per bad access. Pad outputs show a write's effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready, always high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset in the 4 KB window |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, registered |
| rsp_err_o | output | 1 | Unmapped-access pulse |
| pad_out_o | output | 32 | Output latch to the pad resolver |
| pad_dir_o | output | 32 | Direction bits to the pad resolver |
| pad_cfg_o | output | 1024 | Configuration word i in bits [32*i+31:32*i] |
| pad_in_i | input | 32 | Resolved pin levels from the pad resolver |

## Verification
Every access is accepted at one rising edge. Read data, the error flag and the updated latch, direction and configuration outputs are all due right after that edge. The bench drives each request at a falling edge, lets exactly one rising edge pass, and samples every output at the next falling edge. The sampled input path has one extra register, so the bench changes `pad_in_i` and waits two full cycles before it reads offset 0x510. After each error access the bench also samples one idle cycle later, to confirm the flag has dropped.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] OFS_OUT    = 12'h504;
  localparam logic [AW-1:0] OFS_OUTSET = 12'h508;
  localparam logic [AW-1:0] OFS_OUTCLR = 12'h50C;
  localparam logic [AW-1:0] OFS_IN     = 12'h510;
  localparam logic [AW-1:0] OFS_DIR    = 12'h514;
  localparam logic [AW-1:0] OFS_DIRSET = 12'h518;
  localparam logic [AW-1:0] OFS_DIRCLR = 12'h51C;
  localparam logic [AW-1:0] OFS_CFG    = 12'h700;

  localparam logic [DW-1:0] CFG_RESET  = 32'h0000_0002;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_OUT,
    ACC_OUTSET,
    ACC_OUTCLR,
    ACC_IN,
    ACC_DIR,
    ACC_DIRSET,
    ACC_DIRCLR,
    ACC_CFG
  } acc_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [AW-1:0]   addr_i,
  output acc_e            acc_o,
  output logic [IDXW-1:0] idx_o
);
  localparam logic [AW-1:0] CFG_END = OFS_CFG + AW'(4 * NPINS);

  // the config base is aligned to the config span, so the index is a plain bit slice
  assign idx_o = addr_i[2 +: IDXW];

  always_comb begin
    acc_o = ACC_NONE;
    if (addr_i[1:0] == 2'b00) begin
      unique case (addr_i)
        OFS_OUT:    acc_o = ACC_OUT;
        OFS_OUTSET: acc_o = ACC_OUTSET;
        OFS_OUTCLR: acc_o = ACC_OUTCLR;
        OFS_IN:     acc_o = ACC_IN;
        OFS_DIR:    acc_o = ACC_DIR;
        OFS_DIRSET: acc_o = ACC_DIRSET;
        OFS_DIRCLR: acc_o = ACC_DIRCLR;
        default: begin
          if (addr_i >= OFS_CFG && addr_i < CFG_END) acc_o = ACC_CFG;
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int unsigned HW = DW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDXW-1:0]   wr_idx_i,
  input  logic [HW-1:0]     wr_data_i,
  output logic [NPINS*HW-1:0] hi_o
);
  // bits [31:1] per pin; bit 0 is the shared direction bit held in the top
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [HW-1:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  hi_q <= CFG_RESET[DW-1:1];
      else if (wr_en_i && wr_idx_i == IDXW'(i))     hi_q <= wr_data_i;
    end
    assign hi_o[i*HW +: HW] = hi_q;
  end

  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(hi_o));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned IDXW = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int unsigned HW = DW - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [DW-1:0]        req_wdata_i,
  output logic [DW-1:0]        rsp_rdata_o,
  output logic                 rsp_err_o,
  output logic [NPINS-1:0]     pad_out_o,
  output logic [NPINS-1:0]     pad_dir_o,
  output logic [NPINS*DW-1:0]  pad_cfg_o,
  input  logic [NPINS-1:0]     pad_in_i
);
  acc_e              acc;
  logic [IDXW-1:0]   idx;
  logic              wr, rd;
  logic [NPINS-1:0]  out_q, out_d, dir_q, dir_d, in_q;
  logic [NPINS-1:0]  wd;
  logic [NPINS*HW-1:0] cfg_hi;
  logic [DW-1:0]     rd_val, rdata_q;
  logic              err_q;

  assign req_ready_o = 1'b1;
  assign wr = req_valid_i && req_write_i;
  assign rd = req_valid_i && !req_write_i;
  assign wd = req_wdata_i[NPINS-1:0];

  gpio_addr_decode #(.NPINS(NPINS)) u_dec (
    .addr_i (req_addr_i),
    .acc_o  (acc),
    .idx_o  (idx)
  );

  gpio_cfg_bank #(.NPINS(NPINS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr && acc == ACC_CFG),
    .wr_idx_i  (idx),
    .wr_data_i (req_wdata_i[DW-1:1]),
    .hi_o      (cfg_hi)
  );

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (wr) begin
      unique case (acc)
        ACC_OUT:    out_d = wd;
        ACC_OUTSET: out_d = out_q | wd;
        ACC_OUTCLR: out_d = out_q & ~wd;
        ACC_DIR:    dir_d = wd;
        ACC_DIRSET: dir_d = dir_q | wd;
        ACC_DIRCLR: dir_d = dir_q & ~wd;
        ACC_CFG:    dir_d[idx] = req_wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (acc)
      ACC_OUT, ACC_OUTSET, ACC_OUTCLR: rd_val = DW'(out_q);
      ACC_DIR, ACC_DIRSET, ACC_DIRCLR: rd_val = DW'(dir_q);
      ACC_IN:                          rd_val = DW'(in_q);
      ACC_CFG:                         rd_val = {cfg_hi[idx*HW +: HW], dir_q[idx]};
      default:                         rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      in_q    <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
      in_q  <= pad_in_i;
      err_q <= req_valid_i && acc == ACC_NONE;
      if (rd) rdata_q <= rd_val;
    end
  end

  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
  assign pad_out_o   = out_q;
  assign pad_dir_o   = dir_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_cfg_out
    assign pad_cfg_o[i*DW +: DW] = {cfg_hi[i*HW +: HW], dir_q[i]};
  end

  assert_outset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && acc == ACC_OUTSET) |=> pad_out_o == ($past(pad_out_o) | $past(wd)));
  assert_outclr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && acc == ACC_OUTCLR) |=> pad_out_o == ($past(pad_out_o) & ~$past(wd)));
  assert_cfg_dir_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && acc == ACC_CFG) |=> pad_dir_o[$past(idx)] == $past(req_wdata_i[0]));
  assert_bad_write_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && acc == ACC_NONE) |=> ($stable(pad_out_o) && $stable(pad_dir_o) && $stable(pad_cfg_o)));
  assert_bad_read_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && acc == ACC_NONE) |=> (rsp_err_o && rsp_rdata_o == '0));
  assert_err_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_err_o);
endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;
  localparam int unsigned NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ready, err;
  logic [31:0] rdata, pout, pdir, pin = '0;
  logic [NP*32-1:0] pcfg;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_regbank #(.NPINS(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_ready_o(ready),
    .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rdata), .rsp_err_o(err), .pad_out_o(pout),
    .pad_dir_o(pdir), .pad_cfg_o(pcfg), .pad_in_i(pin)
  );

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] rd;
    logic        er;
    logic [31:0] o;
    logic [31:0] dr;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h504, 32'hA5A5_0F0F, 32'h0,         1'b0, 32'hA5A5_0F0F, 32'h0,         8'd2},  // R2
    '{1'b0, 12'h508, 32'h0,         32'hA5A5_0F0F, 1'b0, 32'hA5A5_0F0F, 32'h0,         8'd2},  // R2 alias read
    '{1'b1, 12'h508, 32'h0000_F000, 32'h0,         1'b0, 32'hA5A5_FF0F, 32'h0,         8'd3},  // R3 set
    '{1'b1, 12'h50C, 32'h0000_000F, 32'h0,         1'b0, 32'hA5A5_FF00, 32'h0,         8'd3},  // R3 clear
    '{1'b0, 12'h50C, 32'h0,         32'hA5A5_FF00, 1'b0, 32'hA5A5_FF00, 32'h0,         8'd2},  // R2 alias read
    '{1'b1, 12'h514, 32'h0000_00FF, 32'h0,         1'b0, 32'hA5A5_FF00, 32'h0000_00FF, 8'd4},  // R4
    '{1'b1, 12'h518, 32'h0F00_0000, 32'h0,         1'b0, 32'hA5A5_FF00, 32'h0F00_00FF, 8'd5},  // R5 set
    '{1'b1, 12'h51C, 32'h0000_000F, 32'h0,         1'b0, 32'hA5A5_FF00, 32'h0F00_00F0, 8'd5},  // R5 clear
    '{1'b0, 12'h51C, 32'h0,         32'h0F00_00F0, 1'b0, 32'hA5A5_FF00, 32'h0F00_00F0, 8'd4},  // R4 alias read
    '{1'b0, 12'h700, 32'h0,         32'h0000_0002, 1'b0, 32'hA5A5_FF00, 32'h0F00_00F0, 8'd6},  // R6 pin0 dir 0
    '{1'b0, 12'h710, 32'h0,         32'h0000_0003, 1'b0, 32'hA5A5_FF00, 32'h0F00_00F0, 8'd6},  // R6 pin4 dir 1
    '{1'b1, 12'h704, 32'h0000_070D, 32'h0,         1'b0, 32'hA5A5_FF00, 32'h0F00_00F2, 8'd7},  // R7
    '{1'b0, 12'h704, 32'h0,         32'h0000_070D, 1'b0, 32'hA5A5_FF00, 32'h0F00_00F2, 8'd7},  // R7 readback
    '{1'b1, 12'h514, 32'h0,         32'h0,         1'b0, 32'hA5A5_FF00, 32'h0,         8'd4},  // R4
    '{1'b0, 12'h704, 32'h0,         32'h0000_070C, 1'b0, 32'hA5A5_FF00, 32'h0,         8'd6},  // R6 upper bits kept
    '{1'b1, 12'h800, 32'hFFFF_FFFF, 32'h0,         1'b1, 32'hA5A5_FF00, 32'h0,         8'd9},  // R9 bad write
    '{1'b0, 12'h800, 32'h0,         32'h0,         1'b1, 32'hA5A5_FF00, 32'h0,         8'd9},  // R9 bad read
    '{1'b0, 12'h505, 32'h0,         32'h0,         1'b1, 32'hA5A5_FF00, 32'h0,         8'd9},  // R9 misaligned
    '{1'b1, 12'h510, 32'hFFFF_FFFF, 32'h0,         1'b0, 32'hA5A5_FF00, 32'h0,         8'd8},  // R8 write ignored
    '{1'b0, 12'h77C, 32'h0,         32'h0000_0002, 1'b0, 32'hA5A5_FF00, 32'h0,         8'd7}   // R7 last pin
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge captures, sample at next falling edge
  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", pout, 32'h0);
    check("R1 dir", pdir, 32'h0);
    check("R1 err", {31'h0, err}, 32'h0);
    check("R1 cfg7", pcfg[7*32 +: 32], 32'h2);
    check("R1 cfg31", pcfg[31*32 +: 32], 32'h2);
    check("R10 ready", {31'h0, ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      xfer(VECS[i].w, VECS[i].a, VECS[i].d);
      if (!VECS[i].w) check(tag, rdata, VECS[i].rd);
      check(tag, {31'h0, err}, {31'h0, VECS[i].er});
      check(tag, pout, VECS[i].o);
      check(tag, pdir, VECS[i].dr);
    end

    // R10 error flag lasts one cycle
    xfer(1'b0, 12'hFFC, 32'h0);
    check("R10 err pulse", {31'h0, err}, 32'h1);
    @(negedge clk);
    check("R10 err drop", {31'h0, err}, 32'h0);

    // R8 input sampling
    pin = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    xfer(1'b0, 12'h510, 32'h0);
    check("R8 in read", rdata, 32'hDEAD_BEEF);

    // R7 and R10: config write visible on pad outputs the next cycle
    xfer(1'b1, 12'h77C, 32'h1234_5679);
    check("R7 pad cfg31", pcfg[31*32 +: 32], 32'h1234_5679);
    check("R7 dir31", pdir, 32'h8000_0000);

    // R6: direction set mirrors into config bit 0, upper bits kept
    xfer(1'b1, 12'h518, 32'h0000_0002);
    check("R6 cfg1", pcfg[1*32 +: 32], 32'h0000_070D);
    xfer(1'b1, 12'h51C, 32'h8000_0000);
    check("R6 cfg31", pcfg[31*32 +: 32], 32'h1234_5678);

    // R9: bad write left config untouched
    xfer(1'b1, 12'h780, 32'hFFFF_FFFF);
    check("R9 cfg31 kept", pcfg[31*32 +: 32], 32'h1234_5678);
    check("R9 dir kept", pdir, 32'h0000_0002);

    // R3: set and clear on same bits across a full word
    xfer(1'b1, 12'h504, 32'h0);
    xfer(1'b1, 12'h508, 32'hFFFF_FFFF);
    check("R3 set all", pout, 32'hFFFF_FFFF);
    xfer(1'b1, 12'h50C, 32'h5555_5555);
    check("R3 clr odd", pout, 32'hAAAA_AAAA);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule